// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

This block adds two unsigned binary operands and a carry-in in a single combinational pass, producing an N-bit sum and a carry-out. Carries are never propagated directly. Instead, each bit forms a generate (a AND b), a transmit (a OR b) and a half-sum (a XOR b). A pseudo-carry then travels through the bits, where the pseudo-carry into a bit is the OR of the real carries into that bit and into the bit below it. The real carry and each sum bit are recovered locally from the pseudo-carry and the transmit of the neighbouring bit.

Bits are handled in four-bit groups. Each group computes a lookahead pseudo-carry from a four-term OR and a group transmit. Four groups form a sixteen-bit section. Each section builds two complete results at once, one assuming a section carry-in of 0 and one assuming 1. A short chain of long carries runs across the section boundaries, and each long carry picks one of the two precomputed results for the section above it.

The operand width is a parameter and must be a multiple of sixteen. The block has no state, clock or reset, so it drops straight into any datapath stage that needs an addition.

Top module: `ling_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of the unsigned sum `opA + opB + carryIn`, for every operand pair.
- R2: `carryOut` equals bit WIDTH (the bit just above the top sum bit) of `opA + opB + carryIn`.
- R3: The carry-in acts as a generate below bit 0. With both operands zero, `carryIn`=1 gives `sumOut`=1 and `carryOut`=0, and `carryIn`=0 gives all zeros.
- R4: In each four-bit group, the lookahead pseudo-carry `g3 | g2 | (t2&g1) | (t2&t1&g0)`, combined with the group transmit and the group's incoming pseudo-carry, equals the pseudo-carry produced by the bit-by-bit recurrence H(i+1) = g(i) | (t(i-1) & H(i)).
- R5: A carry created at bit 0 travels through every section boundary. For example, an all-ones operand plus zero with `carryIn`=1 gives `sumOut`=0 and `carryOut`=1.
- R6: Each sixteen-bit section's result computed under a carry-in of 1 equals its result under a carry-in of 0, plus one (modulo 2^16). The section outputs the first result exactly when the long carry into it is 1, so a carry stops at the first section that does not pass it along.
- R7: For each section, a carry-out under a section carry-in of 0 implies a carry-out under a carry-in of 1. When every bit half-sum is 1, the carry-in alone decides every long carry, so complementary alternating operands with `carryIn`=1 give `sumOut`=0 and `carryOut`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
Whenever the inputs settle, the embedded assertions check four things: that every group's four-term lookahead agrees with the bit-by-bit pseudo-carry ripple, that each section's two candidate results differ by exactly one, that the section carry-outs are ordered, and that the top-level result matches arithmetic addition. Only the bench's chosen operand patterns show that a carry really crosses every sixteen-bit boundary, stops at the correct section, and behaves correctly at the all-ones, all-zeros and alternating extremes. These cases are unlikely to arise from random operands alone.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int SECTION_W = 16;
  localparam int GROUP_W   = 4;
  localparam int GROUPS_PER_SECTION = SECTION_W / GROUP_W;

  // Both candidate results of one section
  typedef struct packed {
    logic [SECTION_W-1:0] sumLow;   // section carry-in assumed 0
    logic [SECTION_W-1:0] sumHigh;  // section carry-in assumed 1
    logic                 coutLow;
    logic                 coutHigh;
  } sectionRes_t;
endpackage

// File: rtl/ling_group4.sv
module ling_group4
  import ling_pkg::*;
(
  input  logic [GROUP_W-1:0] genIn,
  input  logic [GROUP_W-1:0] tranIn,
  input  logic [GROUP_W-1:0] halfIn,
  input  logic               tranBelow,   // transmit of the bit under this group
  input  logic               hBaseLow,    // pseudo-carry into group, section cin 0
  input  logic               hBaseHigh,   // pseudo-carry into group, section cin 1
  output logic               grpH,
  output logic               grpT,
  output logic [GROUP_W-1:0] sumLow,
  output logic [GROUP_W-1:0] sumHigh
);
  logic [GROUP_W-1:0] tranShift;
  logic [GROUP_W:0]   hLow, hHigh;

  assign tranShift = {tranIn[GROUP_W-2:0], tranBelow};

  // four-term lookahead pseudo-carry and group transmit
  assign grpH = genIn[3] | genIn[2] | (tranIn[2] & genIn[1])
              | (tranIn[2] & tranIn[1] & genIn[0]);
  assign grpT = &tranShift;

  // local pseudo-carries inside the group, one ripple per assumption
  always_comb begin
    hLow[0]  = hBaseLow;
    hHigh[0] = hBaseHigh;
    for (int i = 0; i < GROUP_W; i++) begin
      hLow[i+1]  = genIn[i] | (tranShift[i] & hLow[i]);
      hHigh[i+1] = genIn[i] | (tranShift[i] & hHigh[i]);
    end
  end

  assign sumLow  = halfIn ^ (tranShift & hLow[GROUP_W-1:0]);
  assign sumHigh = halfIn ^ (tranShift & hHigh[GROUP_W-1:0]);

  // lookahead must agree with the bitwise recurrence
  always_comb begin
    if (!$isunknown({genIn, tranIn, tranBelow, hBaseLow, hBaseHigh})) begin
      p_group_lookahead_r4: assert (hLow[GROUP_W] == (grpH | (grpT & hBaseLow)) &&
                                    hHigh[GROUP_W] == (grpH | (grpT & hBaseHigh)))
        else $error("group lookahead disagrees with ripple");
    end
  end
endmodule

// File: rtl/ling_section16.sv
module ling_section16
  import ling_pkg::*;
(
  input  logic [SECTION_W-1:0] secA,
  input  logic [SECTION_W-1:0] secB,
  output sectionRes_t          secRes
);
  logic [SECTION_W-1:0] genBit, tranBit, halfBit;
  logic [GROUPS_PER_SECTION-1:0] grpH, grpT;
  logic [GROUPS_PER_SECTION:0]   hGrpLow, hGrpHigh;

  assign genBit  = secA & secB;
  assign tranBit = secA | secB;
  assign halfBit = secA ^ secB;

  // pseudo-carry at each group base; below bit 0 the transmit counts as 1
  assign hGrpLow[0]  = 1'b0;
  assign hGrpHigh[0] = 1'b1;

  for (genvar j = 0; j < GROUPS_PER_SECTION; j++) begin : g_grp
    localparam int LO = j * GROUP_W;
    logic tranBelowJ;
    if (j == 0) begin : g_first
      assign tranBelowJ = 1'b1;
    end else begin : g_rest
      assign tranBelowJ = tranBit[LO-1];
    end

    ling_group4 grp_i (
      .genIn    (genBit[LO +: GROUP_W]),
      .tranIn   (tranBit[LO +: GROUP_W]),
      .halfIn   (halfBit[LO +: GROUP_W]),
      .tranBelow(tranBelowJ),
      .hBaseLow (hGrpLow[j]),
      .hBaseHigh(hGrpHigh[j]),
      .grpH     (grpH[j]),
      .grpT     (grpT[j]),
      .sumLow   (secRes.sumLow[LO +: GROUP_W]),
      .sumHigh  (secRes.sumHigh[LO +: GROUP_W])
    );

    assign hGrpLow[j+1]  = grpH[j] | (grpT[j] & hGrpLow[j]);
    assign hGrpHigh[j+1] = grpH[j] | (grpT[j] & hGrpHigh[j]);
  end

  // real carry recovered from the top pseudo-carry
  assign secRes.coutLow  = tranBit[SECTION_W-1] & hGrpLow[GROUPS_PER_SECTION];
  assign secRes.coutHigh = tranBit[SECTION_W-1] & hGrpHigh[GROUPS_PER_SECTION];

  always_comb begin
    if (!$isunknown({secA, secB})) begin
      p_pair_offset_r6: assert ({secRes.coutHigh, secRes.sumHigh} ==
                                {secRes.coutLow, secRes.sumLow} + 17'd1)
        else $error("section candidates not one apart");
      p_cout_order_r7: assert (!secRes.coutLow || secRes.coutHigh)
        else $error("section carry-outs out of order");
    end
  end
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NUM_SEC = WIDTH / SECTION_W;

  if (WIDTH % SECTION_W != 0 || WIDTH < SECTION_W) begin : g_bad_width
    $error("WIDTH must be a positive multiple of 16");
  end

  sectionRes_t        secRes [NUM_SEC];
  logic [NUM_SEC:0]   longCarry;

  assign longCarry[0] = carryIn;

  for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
    ling_section16 sec_i (
      .secA  (opA[k*SECTION_W +: SECTION_W]),
      .secB  (opB[k*SECTION_W +: SECTION_W]),
      .secRes(secRes[k])
    );
    assign longCarry[k+1] = secRes[k].coutLow | (secRes[k].coutHigh & longCarry[k]);
    assign sumOut[k*SECTION_W +: SECTION_W] =
      longCarry[k] ? secRes[k].sumHigh : secRes[k].sumLow;
  end

  assign carryOut = longCarry[NUM_SEC];

  logic [WIDTH:0] arithRef;
  assign arithRef = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      p_sum_exact_r1: assert (sumOut == arithRef[WIDTH-1:0])
        else $error("sum differs from arithmetic");
      p_carry_exact_r2: assert (carryOut == arithRef[WIDTH])
        else $error("carry-out differs from arithmetic");
    end
  end
endmodule

// File: tb/ling_adder_tb.sv
module ling_adder_tb_top;
  localparam int WIDTH  = 64;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIDTH-1:0] opA, opB, sumOut;
  logic carryIn, carryOut;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ling_adder #(.WIDTH(WIDTH)) dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c, input string tag);
    logic [WIDTH:0] expect_v;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    expect_v = WIDTH'(0);
    expect_v = {1'b0, a};
    expect_v = expect_v + {1'b0, b};
    if (c) expect_v = expect_v + 1;
    @(posedge clk);
    #1;
    compared++;
    if (sumOut !== expect_v[WIDTH-1:0]) begin
      mismatched++;
      $display("FAIL %s R1 sum: actual %h expected %h", tag, sumOut, expect_v[WIDTH-1:0]);
    end
    compared++;
    if (carryOut !== expect_v[WIDTH]) begin
      mismatched++;
      $display("FAIL %s R2 carry: actual %b expected %b", tag, carryOut, expect_v[WIDTH]);
    end
  endtask

  function automatic logic [WIDTH-1:0] rnd();
    logic [WIDTH-1:0] v;
    for (int k = 0; k < WIDTH; k++) v[k] = 1'($urandom);
    return v;
  endfunction

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: idle inputs and carry-in alone
    apply('0, '0, 1'b0, "R3 zeros");
    apply('0, '0, 1'b1, "R3 cin only");
    // R5: carry from bit 0 across every section boundary
    apply('1, '0, 1'b1, "R5 ones+cin");
    apply('0, '1, 1'b1, "R5 cin+ones");
    apply('1, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0, "R5 ones+1");
    apply('1, '1, 1'b1, "R5 ones+ones+cin");
    apply('1, '1, 1'b0, "R5 ones+ones");
    // R7: every half-sum set, cin decides all long carries
    apply({(WIDTH/2){2'b01}}, {(WIDTH/2){2'b10}}, 1'b1, "R7 alt cin1");
    apply({(WIDTH/2){2'b01}}, {(WIDTH/2){2'b10}}, 1'b0, "R7 alt cin0");
    apply({(WIDTH/2){2'b01}}, {(WIDTH/2){2'b01}}, 1'b1, "R7 alt same");
    // R6: carry stops at a section that does not pass it
    apply({(WIDTH/32){16'h0000, 16'hFFFF}}, '0, 1'b1, "R6 stop odd");
    apply({(WIDTH/32){16'hFFFF, 16'h0000}}, {{(WIDTH-16){1'b0}}, 16'hFFFF}, 1'b1, "R6 stop even");
    for (int s = 0; s < WIDTH/16; s++) begin
      logic [WIDTH-1:0] a;
      a = '0;
      for (int k = 0; k < 16*(s+1) && k < WIDTH; k++) a[k] = 1'b1;
      apply(a, '0, 1'b1, "R6 boundary walk");
    end
    // R4: a carry generated at each position of a group, then transmitted
    for (int i = 0; i < 8; i++) begin
      logic [WIDTH-1:0] a, b;
      a = '0; b = '0;
      a[i] = 1'b1; b[i] = 1'b1;
      for (int k = i + 1; k < WIDTH; k++) a[k] = 1'b1;
      apply(a, b, 1'b0, "R4 gen position");
      b[i+1] = 1'b1;
      apply(a, b, 1'b0, "R4 gen plus transmit");
    end
    // R1 R2: random operands
    for (int n = 0; n < 400; n++) apply(rnd(), rnd(), 1'($urandom), "R1 random");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired R1: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule